// File: doc/BRIEF.md
# Fault Flag Status Register

This block holds the fault status of a PWM timer. There is one sticky flag for each fault input and one combined flag that covers all of them. A flag is set when three things are true in the same cycle: global fault control is on, the input's own enable is on, and a fault level is present on that input. The fault levels arrive already synchronized.

Software clears a flag in two steps:
1. It reads the status register while the flag is set. This arms the flag.
2. It writes a zero to that flag's bit while the input's enabled fault is absent.

A fresh fault that arrives between the two steps sends the flag back to its unarmed set state, so the write does not clear it. Clearing the combined flag clears every per-input flag at once.

Each flag, including the combined flag, is its own three-state machine:
- **States:** CLEAR, SET (set and unarmed) and ARMED.
- **Transitions:**
  - **assert:** any state to SET, on an enabled fault.
  - **arm:** SET to ARMED, on a read with no write and no fault.
  - **release:** ARMED to CLEAR, on a zero-write with no fault.
  - **cancel:** SET stays SET on any write.
  - **restart:** ARMED to SET, on a fault.
  - **keep:** ARMED stays ARMED on a one-write or a read.
  - **purge:** any per-input state to CLEAR, when the combined flag is released.

Top module: `fault_flag_status`

## Requirements
- R1: A per-input flag becomes 1 in the cycle after `fault_ctl_en`, that input's `fault_in_en` bit and its `fault_lvl` bit are all high together. If any of the three is low, the flag is not set.
- R2: `rd_data` always shows the current flags. Bits [N_IN-1:0] are the per-input flags and bit N_IN is the combined flag. A value of 1 means a fault was detected and 0 means none.
- R3: A read (`rd_stb` without `wr_stb`) arms only the flags that are set at the time of the read and have no enabled fault in that cycle. A read of a clear flag arms nothing.
- R4: A write with `wr_stb` and a 0 in the bit of an armed flag clears that flag at the next edge, provided that input has no enabled fault in the write cycle.
- R5: Writing a 1 to a flag bit changes nothing: the flag stays set and keeps its armed state.
- R6: A zero-write to a set flag that is not armed, or that comes while its input's enabled fault is present, leaves the flag set and unarmed.
- R7: An enabled fault on an input whose flag is armed disarms it, so a later zero-write does not clear it.
- R8: When an enabled fault and a read fall in the same cycle, the fault wins and the read does not arm.
- R9: The combined flag is set whenever any input's enabled fault is present. It is cleared by the same read-then-zero-write handshake on bit N_IN while no enabled fault exists, and its clearing clears all per-input flags.
- R10: A synchronous active-high `rst` clears all flags and arming states.
- R11: When `rd_stb` and `wr_stb` are high in one cycle, the write acts on the arming state from before that cycle and the read arms nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_ctl_en | input | 1 | Global fault control enable |
| fault_in_en | input | N_IN | Per-input fault enables |
| fault_lvl | input | N_IN | Synchronized fault condition levels |
| rd_stb | input | 1 | Status register read strobe |
| wr_stb | input | 1 | Status register write strobe |
| wr_data | input | N_IN+1 | Write data, same layout as `rd_data` |
| flag | output | N_IN | Per-input fault flags |
| any_flag | output | 1 | Combined fault flag |
| rd_data | output | N_IN+1 | Status register read value |

## Verification
The assertions check five rules on every cycle:
- No flag rises without an enabled fault in the cycle before.
- Every enabled fault sets its flag.
- No flag falls without a write strobe, or while its fault was active.
- The combined flag is high whenever a per-input flag is high.
- The combined flag falls only after a zero in its own bit.

Whether a flag was armed by an earlier read depends on history that a single-cycle property cannot follow. The bench's scenarios therefore cover the arm, cancel, restart and priority cases, the purge through the combined flag, and the same-cycle read and write.

// File: rtl/ffs_pkg.sv
package ffs_pkg;
    typedef enum logic [1:0] {
        FS_CLEAR = 2'd0,
        FS_SET   = 2'd1,
        FS_ARMED = 2'd2
    } flag_state_t;
endpackage

// File: rtl/ffs_fault_qualify.sv
module ffs_fault_qualify #(
    parameter int N_IN = 4
) (
    input  logic            ctl_en_i,
    input  logic [N_IN-1:0] in_en_i,
    input  logic [N_IN-1:0] lvl_i,
    output logic [N_IN-1:0] hit_o,
    output logic            any_hit_o
);
    always_comb begin
        hit_o     = {N_IN{ctl_en_i}} & in_en_i & lvl_i;
        any_hit_o = |hit_o;
    end
endmodule

// File: rtl/ffs_flag_fsm.sv
module ffs_flag_fsm
    import ffs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wr_bit_i,
    input  logic purge_i,
    output logic flag_o,
    output logic release_o
);
    flag_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= FS_CLEAR;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (purge_i) begin
            state_d = FS_CLEAR;
        end else begin
            unique case (state_q)
                FS_CLEAR: if (set_i) state_d = FS_SET;
                FS_SET: begin
                    if (set_i)     state_d = FS_SET;
                    else if (wr_i) state_d = FS_SET;
                    else if (rd_i) state_d = FS_ARMED;
                end
                FS_ARMED: begin
                    if (set_i)                  state_d = FS_SET;
                    else if (wr_i && !wr_bit_i) state_d = FS_CLEAR;
                end
                default: state_d = FS_CLEAR;
            endcase
        end
    end

    always_comb begin
        flag_o    = (state_q != FS_CLEAR);
        release_o = (state_q == FS_ARMED) && !set_i && wr_i && !wr_bit_i;
    end
endmodule

// File: rtl/fault_flag_status.sv
module fault_flag_status #(
    parameter int N_IN = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            fault_ctl_en,
    input  logic [N_IN-1:0] fault_in_en,
    input  logic [N_IN-1:0] fault_lvl,
    input  logic            rd_stb,
    input  logic            wr_stb,
    input  logic [N_IN:0]   wr_data,
    output logic [N_IN-1:0] flag,
    output logic            any_flag,
    output logic [N_IN:0]   rd_data
);
    localparam int ANY_BIT = N_IN;

    logic [N_IN-1:0] hit;
    logic            any_hit;
    logic            any_release;
    logic [N_IN-1:0] in_release;

    ffs_fault_qualify #(.N_IN(N_IN)) u_qual (
        .ctl_en_i (fault_ctl_en),
        .in_en_i  (fault_in_en),
        .lvl_i    (fault_lvl),
        .hit_o    (hit),
        .any_hit_o(any_hit)
    );

    ffs_flag_fsm u_any (
        .clk      (clk),
        .rst      (rst),
        .set_i    (any_hit),
        .rd_i     (rd_stb),
        .wr_i     (wr_stb),
        .wr_bit_i (wr_data[ANY_BIT]),
        .purge_i  (1'b0),
        .flag_o   (any_flag),
        .release_o(any_release)
    );

    for (genvar g = 0; g < N_IN; g++) begin : g_in
        ffs_flag_fsm u_flag (
            .clk      (clk),
            .rst      (rst),
            .set_i    (hit[g]),
            .rd_i     (rd_stb),
            .wr_i     (wr_stb),
            .wr_bit_i (wr_data[g]),
            .purge_i  (any_release),
            .flag_o   (flag[g]),
            .release_o(in_release[g])
        );
    end

    always_comb rd_data = {any_flag, flag};
endmodule

// File: rtl/ffs_checker.sv
module ffs_checker #(
    parameter int N_IN = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            fault_ctl_en,
    input logic [N_IN-1:0] fault_in_en,
    input logic [N_IN-1:0] fault_lvl,
    input logic            wr_stb,
    input logic [N_IN:0]   wr_data,
    input logic [N_IN-1:0] flag,
    input logic            any_flag
);
    logic [N_IN-1:0] en_vec;
    always_comb en_vec = {N_IN{fault_ctl_en}} & fault_in_en & fault_lvl;

    AST_NO_SET_UNQUALIFIED: assert property (@(posedge clk) disable iff (rst)
        ((flag & ~$past(flag) & ~$past(en_vec)) == '0)); // R1
    AST_FAULT_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        ((($past(en_vec) & ~flag)) == '0)); // R8
    AST_FALL_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (|($past(flag) & ~flag)) |-> $past(wr_stb)); // R4
    AST_FALL_NOT_IN_FAULT: assert property (@(posedge clk) disable iff (rst)
        (($past(flag) & ~flag & $past(en_vec)) == '0)); // R6
    AST_ANY_COVERS: assert property (@(posedge clk) disable iff (rst)
        (|flag) |-> any_flag); // R9
    AST_ANY_FALL_ZERO: assert property (@(posedge clk) disable iff (rst)
        $fell(any_flag) |-> ($past(wr_stb) && !$past(wr_data[N_IN]))); // R9
endmodule

bind fault_flag_status ffs_checker #(.N_IN(N_IN)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .fault_ctl_en(fault_ctl_en),
    .fault_in_en (fault_in_en),
    .fault_lvl   (fault_lvl),
    .wr_stb      (wr_stb),
    .wr_data     (wr_data),
    .flag        (flag),
    .any_flag    (any_flag)
);

// File: tb/fault_flag_status_tb.sv
`timescale 1ns/1ps
module fault_flag_status_tb;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ctl = 1'b0;
    logic [N-1:0] en  = '0;
    logic [N-1:0] lvl = '0;
    logic         rd  = 1'b0;
    logic         wr  = 1'b0;
    logic [N:0]   wd  = '0;
    logic [N-1:0] flag;
    logic         any_flag;
    logic [N:0]   rd_data;

    int n_chk  = 0;
    int n_fail = 0;
    int m_st [0:N];   // 0 clear, 1 set, 2 armed; index N is the combined flag

    always #2 clk = ~clk;

    fault_flag_status #(.N_IN(N)) u_dut (
        .clk(clk), .rst(rst), .fault_ctl_en(ctl), .fault_in_en(en),
        .fault_lvl(lvl), .rd_stb(rd), .wr_stb(wr), .wr_data(wd),
        .flag(flag), .any_flag(any_flag), .rd_data(rd_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int nxt(int s, bit set, bit r, bit w, bit b, bit purge);
        if (purge) return 0;                   // R9 purge
        if (set) return 1;                     // R1, R7, R8
        if (s == 1 && !w && r) return 2;       // R3, R11
        if (s == 2 && w && !b) return 0;       // R4 (b=1 keeps: R5)
        return s;                              // R6
    endfunction

    function automatic logic [N:0] model_reg();
        logic [N:0] v;
        for (int i = 0; i <= N; i++) v[i] = (m_st[i] != 0);
        return v;
    endfunction

    task automatic cyc(input bit c, input logic [N-1:0] e, input logic [N-1:0] l,
                       input bit r, input bit w, input logic [N:0] d);
        logic [N-1:0] h;
        bit any_rel;
        ctl = c; en = e; lvl = l; rd = r; wr = w; wd = d;
        #0;
        chk("R2 rd_data", rd_data, model_reg());
        h = {N{c}} & e & l;
        any_rel = (m_st[N] == 2) && !(|h) && w && !d[N];
        m_st[N] = nxt(m_st[N], |h, r, w, d[N], 1'b0);
        for (int i = 0; i < N; i++) m_st[i] = nxt(m_st[i], h[i], r, w, d[i], any_rel);
        @(posedge clk); #1;
        chk("R2 flags", {any_flag, flag}, model_reg());
    endtask

    task automatic do_reset();
        rst = 1'b1; rd = 0; wr = 0; lvl = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        for (int i = 0; i <= N; i++) m_st[i] = 0;
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  %0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        do_reset();
        chk("R10 reset state", rd_data, '0);
        // R1: set only with all three qualifiers
        cyc(1, 4'hD, 4'h2, 0, 0, '0);  chk("R1 disabled input", flag, 4'h0);
        cyc(0, 4'hF, 4'h2, 0, 0, '0);  chk("R1 global off", flag, 4'h0);
        cyc(1, 4'hF, 4'h1, 0, 0, '0);  chk("R1 set", flag, 4'h1); chk("R9 any set", any_flag, 1'b1);
        // R6: unarmed zero-write
        cyc(1, 4'hF, 4'h0, 0, 1, 5'h00); chk("R6 unarmed write", flag, 4'h1);
        // R5 then R4
        cyc(1, 4'hF, 4'h0, 1, 0, '0);
        cyc(1, 4'hF, 4'h0, 0, 1, 5'h1F); chk("R5 write one", rd_data, 5'h11);
        cyc(1, 4'hF, 4'h0, 0, 1, 5'h10); chk("R4 clear", rd_data, 5'h10);
        // R8: read in a fault cycle does not arm
        cyc(1, 4'hF, 4'h4, 1, 0, '0);
        cyc(1, 4'hF, 4'h0, 0, 1, 5'h10); chk("R8 set wins", flag, 4'h4);
        // R7: fault after arming restarts
        cyc(1, 4'hF, 4'h0, 1, 0, '0);
        cyc(1, 4'hF, 4'h4, 0, 0, '0);
        cyc(1, 4'hF, 4'h0, 0, 1, 5'h10); chk("R7 restart", flag, 4'h4);
        // R6: write while fault active
        cyc(1, 4'hF, 4'h0, 1, 0, '0);
        cyc(1, 4'hF, 4'h4, 0, 1, 5'h10); chk("R6 fault active", flag, 4'h4);
        // R11: read and write together
        cyc(1, 4'hF, 4'h0, 1, 1, 5'h10); chk("R11 same cycle", flag, 4'h4);
        cyc(1, 4'hF, 4'h0, 0, 1, 5'h10); chk("R11 read did not arm", flag, 4'h4);
        // R3: read of a clear flag arms nothing
        cyc(1, 4'hF, 4'h0, 1, 0, '0);
        cyc(1, 4'hF, 4'h8, 0, 0, '0);
        cyc(1, 4'hF, 4'h0, 0, 1, 5'h1B); chk("R3 no arm on clear", flag, 4'h8);
        // R9: combined clear purges all
        cyc(1, 4'hF, 4'h0, 1, 0, '0);
        cyc(1, 4'hF, 4'h0, 0, 1, 5'h0F); chk("R9 purge", rd_data, 5'h00);
        // random phase
        for (int k = 0; k < 4000; k++) begin
            logic [N-1:0] l;
            bit storm;
            storm = ((k / 30) % 2) == 0;
            l = '0;
            for (int i = 0; i < N; i++) l[i] = storm && (($urandom % 8) == 0);
            cyc(($urandom % 16) != 0, 4'($urandom) | 4'h5, l,
                ($urandom % 3) == 0, ($urandom % 3) == 1,
                (($urandom % 2) == 0) ? 5'($urandom) : 5'h00);
        end
        // R10: reset in the middle clears flags
        cyc(1, 4'hF, 4'hF, 0, 0, '0);
        do_reset();
        chk("R10 mid reset", rd_data, '0);
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule